// File: doc/BRIEF.md
# Serial Pattern Unlock Detector

This block sits between a host bus and an external memory. It watches the chip-enable-in, output-enable and write-enable strobes of every bus cycle. It opens a hidden register path only after it receives a fixed 64-bit key, one bit per write cycle on a single data line. A read cycle arms a recognition attempt. The write cycles that follow must present the key bits in order. A read in the middle of an attempt starts it over. A single wrong bit shuts out the rest of the attempt until the next read.

While the block is locked, chip-enable-out mirrors chip-enable-in, so every cycle reaches the memory. Once the key has been matched, the block raises `unlocked` for a downstream transfer engine. It holds chip-enable-out inactive for the next 64 bus cycles, then locks again. A power-fail input forces chip-enable-out inactive and abandons any attempt or transfer in progress.

The strobes are sampled on the block clock and pass through one register stage. A bus cycle must keep its strobes steady for at least two clocks and then leave them inactive for at least two clocks.

Top module: `pud_top`

## Requirements
- R1: After reset `unlocked` is 0, and with `pwr_fail` low `ce_out_n` equals `ce_in_n`.
- R2: A bus cycle begins on the first sampled clock on which `ce_in_n` is 0 and `oe_n` or `we_n` is 0, after a clock with no cycle active. If `we_n` is 0 the cycle is a write, even when `oe_n` is also 0; otherwise it is a read. The write's key bit is `d_in` sampled on that first clock. Strobe activity while `ce_in_n` is 1 is not a cycle.
- R3: A read cycle arms recognition with the pointer at key bit 0. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, each byte sent least significant bit first. After 64 consecutive matching write cycles, `unlocked` rises once the 64th write cycle ends, and not before.
- R4: A write bit that differs from the key bit at the pointer locks out the attempt. Later writes are ignored, including correct ones, until a read cycle re-arms recognition.
- R5: A read cycle during recognition aborts the attempt. Only a full 64-bit key after that read unlocks the block.
- R6: Write cycles with no arming read before them never unlock the block.
- R7: While `unlocked` is 1, `ce_out_n` is 1. The block stays unlocked for 64 further bus cycles, reads or writes, and locks again when the 64th of them ends. After that `ce_out_n` follows `ce_in_n` again.
- R8: While `pwr_fail` is 1, `ce_out_n` is 1. Power fail also clears `unlocked` and any partial key, so a later unlock needs a fresh read and all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_in_n | input | 1 | Chip enable from the host, active low |
| oe_n | input | 1 | Output enable from the host, active low |
| we_n | input | 1 | Write enable from the host, active low |
| d_in | input | 1 | Serial data bit presented on write cycles |
| pwr_fail | input | 1 | Power-fail indication, active high |
| unlocked | output | 1 | High while the hidden transfer window is open |
| ce_out_n | output | 1 | Gated chip enable to the external memory, active low |

## Verification
The embedded properties check the following on every cycle:
- Start events are mutually exclusive, and a read never registers as a write.
- Each matching write advances the pointer by exactly one.
- A locked-out attempt stays locked out until a read arrives.
- Any read outside the transfer window rewinds the pointer to zero.
- The window opens only from a full pointer, and closes after the set number of cycles.
- Power fail returns the sequencer to idle.

Only the directed scenarios can show the following:
- The key itself is correct, including its byte order and its least-significant-bit-first order.
- The block stays locked after 63 writes and unlocks only at the end of the 64th.
- Host cycles made with chip enable inactive are invisible to the detector.
- The memory sees the right chip enable before, during and after the transfer window.

// File: rtl/pud_pkg.sv
package pud_pkg;

  // Sequencer states: waiting for arm, hunting the key, locked out, window open
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_JAM  = 2'd2,
    ST_OPEN = 2'd3
  } pud_state_e;

  // Four key bytes, lowest byte first in the word; the 64-bit key is two copies
  localparam logic [31:0] PUD_KEY_HALF = 32'h5CA3_3AC5;

endpackage

// File: rtl/pud_cycle_sense.sv
module pud_cycle_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic d_in,
  output logic rd_start,
  output logic wr_start,
  output logic cyc_end,
  output logic d_bit
);

  logic ce_q, oe_q, we_q, d_q, act_q;
  logic act_now;

  // next-state / decode
  always_comb begin
    act_now  = ~ce_q & (~oe_q | ~we_q);
    rd_start = act_now & ~act_q & we_q;
    wr_start = act_now & ~act_q & ~we_q;
    cyc_end  = ~act_now & act_q;
    d_bit    = d_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      oe_q  <= 1'b1;
      we_q  <= 1'b1;
      d_q   <= 1'b0;
      act_q <= 1'b0;
    end else begin
      ce_q  <= ce_in_n;
      oe_q  <= oe_n;
      we_q  <= we_n;
      d_q   <= d_in;
      act_q <= act_now;
    end
  end

  // R2: at most one cycle event per clock
  a_r2_event_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, wr_start, cyc_end}));

  // R2: a start is always followed by the cycle still active or ending, never a second start
  a_r2_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start || wr_start) |=> !(rd_start || wr_start));

endmodule

// File: rtl/pud_key_tap.sv
module pud_key_tap #(
  parameter int              KEY_BITS  = 64,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = '0,
  localparam int             PTR_W     = $clog2(KEY_BITS + 1),
  localparam int             IDX_W     = $clog2(KEY_BITS)
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             key_bit
);

  logic [KEY_BITS-1:0] sel;

  // one-hot position decode against the key, one term per key bit
  for (genvar g = 0; g < KEY_BITS; g++) begin : g_tap
    assign sel[g] = (ptr == PTR_W'(g)) & KEY_VALUE[g];
  end

  assign key_bit = |sel;

  // R3: the tap reports a bit only for pointer values inside the key
  a_r3_tap_range: assert final (!(key_bit && (ptr >= PTR_W'(KEY_BITS))));

endmodule

// File: rtl/pud_seq_fsm.sv
module pud_seq_fsm
  import pud_pkg::*;
#(
  parameter int  KEY_BITS    = 64,
  parameter int  XFER_CYCLES = 64,
  localparam int PTR_W       = $clog2(KEY_BITS + 1),
  localparam int CNT_W       = $clog2(XFER_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic             wr_start,
  input  logic             cyc_end,
  input  logic             d_bit,
  input  logic             key_bit,
  input  logic             pwr_fail,
  output pud_state_e       state,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(KEY_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(XFER_CYCLES);

  pud_state_e       state_d;
  logic [PTR_W-1:0] ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             any_start;

  assign any_start = rd_start | wr_start;

  // next-state
  always_comb begin
    state_d = state;
    ptr_d   = ptr;
    cnt_d   = cnt_q;
    if (pwr_fail) begin
      state_d = ST_IDLE;
      ptr_d   = '0;
      cnt_d   = '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_JAM: begin
          if (rd_start) begin
            state_d = ST_HUNT;
            ptr_d   = '0;
          end
        end
        ST_HUNT: begin
          if (rd_start) begin
            ptr_d = '0;
          end else if (wr_start && (ptr != PTR_FULL)) begin
            if (d_bit == key_bit) ptr_d = ptr + 1'b1;
            else                  state_d = ST_JAM;
          end else if (cyc_end && (ptr == PTR_FULL)) begin
            state_d = ST_OPEN;
            cnt_d   = '0;
          end
        end
        ST_OPEN: begin
          if (any_start && (cnt_q != CNT_FULL)) begin
            cnt_d = cnt_q + 1'b1;
          end else if (cyc_end && (cnt_q == CNT_FULL)) begin
            state_d = ST_IDLE;
            ptr_d   = '0;
            cnt_d   = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ptr   <= '0;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      ptr   <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: a matching write moves the pointer forward by exactly one
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && wr_start && !rd_start && !pwr_fail && ptr != PTR_FULL && d_bit == key_bit)
    |=> (ptr == $past(ptr) + 1'b1));

  // R3: the window opens only after the pointer has covered the whole key
  a_r3_open_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && $past(state) != ST_OPEN) |-> ($past(ptr) == PTR_FULL));

  // R4: once locked out, only a read (or power fail) leaves that state
  a_r4_jam_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_JAM && !rd_start && !pwr_fail) |=> (state == ST_JAM));

  // R5: a read outside the window rewinds to a fresh attempt
  a_r5_read_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !pwr_fail && state != ST_OPEN) |=> (state == ST_HUNT && ptr == '0));

  // R7: the transfer count never passes its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R7: the end of the last transfer cycle closes the window
  a_r7_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && cyc_end && cnt_q == CNT_FULL && !pwr_fail) |=> (state == ST_IDLE));

  // R8: power fail abandons everything
  a_r8_pf_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (state == ST_IDLE && ptr == '0));

endmodule

// File: rtl/pud_top.sv
module pud_top
  import pud_pkg::*;
#(
  parameter int                  KEY_BITS    = 64,
  parameter logic [KEY_BITS-1:0] KEY_VALUE   = {2{PUD_KEY_HALF}},
  parameter int                  XFER_CYCLES = 64,
  parameter int                  RST_STAGES  = 2,
  localparam int                 PTR_W       = $clog2(KEY_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic d_in,
  input  logic pwr_fail,
  output logic unlocked,
  output logic ce_out_n
);

  // asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  logic             rd_start, wr_start, cyc_end, d_bit, key_bit;
  logic [PTR_W-1:0] ptr;
  pud_state_e       state;

  pud_cycle_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_in_n  (ce_in_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .d_in     (d_in),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .cyc_end  (cyc_end),
    .d_bit    (d_bit)
  );

  pud_key_tap #(
    .KEY_BITS  (KEY_BITS),
    .KEY_VALUE (KEY_VALUE)
  ) u_tap (
    .ptr     (ptr),
    .key_bit (key_bit)
  );

  pud_seq_fsm #(
    .KEY_BITS    (KEY_BITS),
    .XFER_CYCLES (XFER_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .cyc_end  (cyc_end),
    .d_bit    (d_bit),
    .key_bit  (key_bit),
    .pwr_fail (pwr_fail),
    .state    (state),
    .ptr      (ptr)
  );

  assign unlocked = (state == ST_OPEN);
  assign ce_out_n = ce_in_n | unlocked | pwr_fail;

  // R7: an open window never coincides with a live key hunt pointer reset
  a_r7_open_ptr_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unlocked |-> (ptr == PTR_W'(KEY_BITS)));

endmodule

// File: tb/pud_top_tb.sv
module pud_top_tb_top;

  logic clk = 1'b0;
  logic rst_n, ce_in_n, oe_n, we_n, d_in, pwr_fail;
  logic unlocked, ce_out_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pud_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_in_n  (ce_in_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .d_in     (d_in),
    .pwr_fail (pwr_fail),
    .unlocked (unlocked),
    .ce_out_n (ce_out_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // key bytes C5 3A A3 5C twice, each least significant bit first
  function automatic bit kbit(input int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic cyc_begin(input bit wr, input bit d, input bit both);
    @(negedge clk);
    ce_in_n = 1'b0;
    if (wr) begin we_n = 1'b0; if (both) oe_n = 1'b0; end
    else oe_n = 1'b0;
    d_in = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic cyc_finish();
    ce_in_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus(input bit wr, input bit d);
    cyc_begin(wr, d, 1'b0);
    cyc_finish();
  endtask

  task automatic send_key(input int first, input int last, input int flip_at);
    for (int i = first; i <= last; i++) bus(1'b1, kbit(i) ^ (i == flip_at));
  endtask

  task automatic arm_and_unlock();
    bus(1'b0, 1'b0);
    send_key(0, 63, -1);
  endtask

  task automatic drain();
    for (int i = 0; i < 64; i++) bus(i % 2, 1'b1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 unlocked after reset", unlocked, 1'b0);
    ce_in_n = 1'b0;
    @(negedge clk);
    chk("R1 ce_out follows low", ce_out_n, 1'b0);
    ce_in_n = 1'b1;
    @(negedge clk);
    chk("R1 ce_out follows high", ce_out_n, 1'b1);
  endtask

  task automatic t_no_arm();
    send_key(0, 63, -1);
    chk("R6 writes without arming read", unlocked, 1'b0);
  endtask

  task automatic t_unlock_window();
    bus(1'b0, 1'b0);
    send_key(0, 62, -1);
    chk("R3 locked after 63 bits", unlocked, 1'b0);
    cyc_begin(1'b1, kbit(63), 1'b0);
    chk("R3 locked during 64th write", unlocked, 1'b0);
    chk("R3 memory sees 64th write", ce_out_n, 1'b0);
    cyc_finish();
    chk("R3 unlocked after 64th write", unlocked, 1'b1);
    cyc_begin(1'b0, 1'b0, 1'b0);
    chk("R7 memory disabled in window", ce_out_n, 1'b1);
    cyc_finish();
    for (int i = 1; i < 63; i++) bus(i % 2, 1'b0);
    chk("R7 open after 63 transfers", unlocked, 1'b1);
    cyc_begin(1'b1, 1'b0, 1'b0);
    chk("R7 open during 64th transfer", unlocked, 1'b1);
    chk("R7 memory disabled in 64th", ce_out_n, 1'b1);
    cyc_finish();
    chk("R7 relocked after 64 transfers", unlocked, 1'b0);
    cyc_begin(1'b0, 1'b0, 1'b0);
    chk("R7 ce_out follows after relock", ce_out_n, 1'b0);
    cyc_finish();
  endtask

  task automatic t_mismatch();
    bus(1'b0, 1'b0);
    send_key(0, 63, 10);
    chk("R4 single bad bit blocks unlock", unlocked, 1'b0);
    send_key(11, 63, -1);
    chk("R4 later correct writes ignored", unlocked, 1'b0);
    arm_and_unlock();
    chk("R4 read re-arms after lockout", unlocked, 1'b1);
    drain();
    chk("R7 drained after R4 test", unlocked, 1'b0);
  endtask

  task automatic t_read_abort();
    bus(1'b0, 1'b0);
    send_key(0, 29, -1);
    bus(1'b0, 1'b0);
    send_key(30, 63, -1);
    chk("R5 read mid-key aborts", unlocked, 1'b0);
    bus(1'b0, 1'b0);
    send_key(0, 29, -1);
    arm_and_unlock();
    chk("R5 full key after abort unlocks", unlocked, 1'b1);
    drain();
  endtask

  task automatic t_interleave();
    bus(1'b0, 1'b0);
    send_key(0, 31, -1);
    // strobes with chip enable inactive, wrong data
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); we_n = 1'b0; oe_n = i[0]; d_in = ~kbit(32);
      repeat (3) @(negedge clk);
      we_n = 1'b1; oe_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    for (int i = 32; i < 64; i++) begin
      cyc_begin(1'b1, kbit(i), i[0]);  // odd bits with both strobes low
      cyc_finish();
    end
    chk("R2 unselected strobes ignored, dual-strobe is write", unlocked, 1'b1);
    drain();
    chk("R2 drained after interleave", unlocked, 1'b0);
  endtask

  task automatic t_power_fail();
    bus(1'b0, 1'b0);
    send_key(0, 31, -1);
    @(negedge clk); pwr_fail = 1'b1;
    ce_in_n = 1'b0;
    @(negedge clk);
    chk("R8 ce_out forced high", ce_out_n, 1'b1);
    ce_in_n = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    repeat (2) @(negedge clk);
    send_key(32, 63, -1);
    chk("R8 partial key cleared", unlocked, 1'b0);
    arm_and_unlock();
    chk("R8 unlock before pf", unlocked, 1'b1);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R8 pf closes window", unlocked, 1'b0);
    pwr_fail = 1'b0;
    cyc_begin(1'b0, 1'b0, 1'b0);
    chk("R8 ce_out follows after pf", ce_out_n, 1'b0);
    cyc_finish();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_in_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    d_in = 1'b0; pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_arm();
    t_unlock_window();
    t_mismatch();
    t_read_abort();
    t_interleave();
    t_power_fail();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule